// File: doc/BRIEF.md
# General-Purpose Output Pin Controller with Interrupt Pulser

This block drives one general-purpose output pin and its tri-state enable from a 16-bit configuration word. A 2-bit mode field chooses among four pin behaviours: floating, interrupt output, driven low and driven high. In interrupt mode the pin idles high and drops low for a fixed number of slow timer ticks. A pulse is started by either of two events, each with its own enable bit: the end of a seek/tune operation, or new radio data being ready.

While a seek/tune operation is in flight and its completion interrupt is enabled, radio-data events are discarded, so the first pulse after the operation starts is always the completion pulse. Events that arrive while a pulse is already running are dropped. Leaving interrupt mode aborts a running pulse.

The pulse width is counted on a millisecond-rate tick. The number of ticks is a parameter and defaults to five, which gives 5 ms at a 1 kHz tick. Every output is registered, so a configuration change or event sampled on one clock edge shows on the pin just after that edge.

Top module: `gpo_irq_pulser`

## Requirements
- R1: While rst_ni is low, pin_oe_o and pin_o are both 0.
- R2: Mode field cfg_i[3:2] = 2'b00 floats the pin: pin_oe_o = 0 and pin_o = 0 after the next clock edge.
- R3: Mode 2'b10 drives pin_oe_o = 1 with pin_o = 0, and mode 2'b11 drives pin_oe_o = 1 with pin_o = 1, from the next clock edge.
- R4: Mode 2'b01 (interrupt) drives pin_oe_o = 1 and holds pin_o = 1 while no pulse runs.
- R5: In interrupt mode with cfg_i[14] = 1, an op_done_i strobe pulls pin_o low from the next edge until the edge that samples the PULSE_TICKS-th tick_i after the pulse began. A tick in the starting cycle is not counted.
- R6: In interrupt mode with cfg_i[15] = 1, an rds_rdy_i strobe starts the same low pulse, unless R8 suppresses it.
- R7: A strobe whose enable bit (cfg_i[14] for op_done_i, cfg_i[15] for rds_rdy_i) is 0 starts no pulse.
- R8: With cfg_i[14] = 1, rds_rdy_i strobes from an op_start_i strobe up to the matching op_done_i are dropped and never replayed. Radio-data pulses resume after the completion.
- R9: Events arriving while a pulse is low are dropped and neither restart nor lengthen it.
- R10: Moving the mode away from 2'b01 aborts a running pulse. The pin shows the new mode's level after the next edge, and returning to 2'b01 gives the idle high level.
- R11: op_done_i and rds_rdy_i in the same cycle give exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 16 | Configuration word: [15] radio-data enable, [14] completion enable, [3:2] pin mode |
| op_start_i | input | 1 | One-cycle strobe, seek/tune started |
| op_done_i | input | 1 | One-cycle strobe, seek/tune completed |
| rds_rdy_i | input | 1 | One-cycle strobe, radio data ready |
| tick_i | input | 1 | One-cycle millisecond-rate tick |
| pin_o | output | 1 | Pin value |
| pin_oe_o | output | 1 | Pin output enable (0 = high impedance) |

## Verification
The assertions assume that strobes and ticks each last a single cycle, and that every op_start_i is eventually followed by one op_done_i and never coincides with it. They also assume tick_i is sparse compared with the clock. The stimulus keeps to these rules by construction: every strobe comes from a task that raises it for one cycle, start and done are always issued cycles apart, and the tick generator fires once every four clocks. Configuration changes, including changes in the middle of a pulse, are applied on falling edges only.

// File: rtl/gpo_pulser_pkg.sv
package gpo_pulser_pkg;

  typedef enum logic [1:0] {
    PIN_FLOAT = 2'b00,
    PIN_IRQ   = 2'b01,
    PIN_LOW   = 2'b10,
    PIN_HIGH  = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic      rds_en;
    logic      done_en;
    pin_mode_e mode;
  } gpo_cfg_t;

  typedef struct packed {
    logic start;
    logic done;
    logic rds;
  } gpo_evt_t;

endpackage

// File: rtl/gpo_op_tracker.sv
module gpo_op_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o
);

  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (start_i) busy_q <= 1'b1;
    else if (done_i)  busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/gpo_event_arb.sv
module gpo_event_arb
  import gpo_pulser_pkg::*;
(
  input  gpo_cfg_t cfg_i,
  input  gpo_evt_t evt_i,
  input  logic     op_busy_i,
  input  logic     pulse_busy_i,
  output logic     fire_o
);

  logic done_hit;
  logic rds_hit;
  logic rds_blocked;

  // completion wins: radio data is masked while an operation is pending
  assign rds_blocked = cfg_i.done_en & (op_busy_i | evt_i.start);
  assign done_hit    = evt_i.done & cfg_i.done_en;
  assign rds_hit     = evt_i.rds & cfg_i.rds_en & ~rds_blocked;

  assign fire_o = (cfg_i.mode == PIN_IRQ) & ~pulse_busy_i & (done_hit | rds_hit);

endmodule

// File: rtl/gpo_pulse_timer.sv
module gpo_pulse_timer #(
  parameter int unsigned PULSE_TICKS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic cancel_i,
  input  logic tick_i,
  output logic active_o,
  output logic active_d_o
);

  localparam int unsigned CNT_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;

  logic active_q, active_d;

  generate
    if (PULSE_TICKS > 1) begin : g_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_TICKS - 1);
      logic [CNT_W-1:0] cnt_q, cnt_d;

      always_comb begin
        active_d = active_q;
        cnt_d    = cnt_q;
        if (cancel_i) begin
          active_d = 1'b0;
          cnt_d    = '0;
        end else if (active_q) begin
          if (tick_i) begin
            if (cnt_q == LAST) begin
              active_d = 1'b0;
              cnt_d    = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end else if (fire_i) begin
          active_d = 1'b1;
          cnt_d    = '0;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end
    end else begin : g_single
      always_comb begin
        active_d = active_q;
        if (cancel_i)               active_d = 1'b0;
        else if (active_q)          active_d = ~tick_i;
        else if (fire_i)            active_d = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_d;
  end

  assign active_o   = active_q;
  assign active_d_o = active_d;

endmodule

// File: rtl/gpo_pin_drive.sv
module gpo_pin_drive
  import gpo_pulser_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pin_mode_e mode_i,
  input  logic      pulse_i,
  output logic      pin_o,
  output logic      pin_oe_o
);

  logic pin_d, oe_d;
  logic pin_q, oe_q;

  always_comb begin
    unique case (mode_i)
      PIN_FLOAT: begin pin_d = 1'b0;     oe_d = 1'b0; end
      PIN_IRQ:   begin pin_d = ~pulse_i; oe_d = 1'b1; end
      PIN_LOW:   begin pin_d = 1'b0;     oe_d = 1'b1; end
      PIN_HIGH:  begin pin_d = 1'b1;     oe_d = 1'b1; end
      default:   begin pin_d = 1'b0;     oe_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      pin_q <= pin_d;
      oe_q  <= oe_d;
    end
  end

  assign pin_o    = pin_q;
  assign pin_oe_o = oe_q;

endmodule

// File: rtl/gpo_irq_pulser.sv
module gpo_irq_pulser
  import gpo_pulser_pkg::*;
#(
  parameter int unsigned CFG_W       = 16,
  parameter int unsigned MODE_LSB    = 2,
  parameter int unsigned DONE_EN_BIT = 14,
  parameter int unsigned RDS_EN_BIT  = 15,
  parameter int unsigned PULSE_TICKS = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             op_start_i,
  input  logic             op_done_i,
  input  logic             rds_rdy_i,
  input  logic             tick_i,
  output logic             pin_o,
  output logic             pin_oe_o
);

  gpo_cfg_t cfg;
  gpo_evt_t evt;
  logic     op_busy;
  logic     fire;
  logic     pulse_q, pulse_d;
  logic     cancel;
  logic     unused_cfg;

  assign cfg.mode    = pin_mode_e'(cfg_i[MODE_LSB +: 2]);
  assign cfg.done_en = cfg_i[DONE_EN_BIT];
  assign cfg.rds_en  = cfg_i[RDS_EN_BIT];
  assign unused_cfg  = ^cfg_i;

  assign evt.start = op_start_i;
  assign evt.done  = op_done_i;
  assign evt.rds   = rds_rdy_i;

  assign cancel = (cfg.mode != PIN_IRQ);

  gpo_op_tracker u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (op_start_i),
    .done_i  (op_done_i),
    .busy_o  (op_busy)
  );

  gpo_event_arb u_arb (
    .cfg_i        (cfg),
    .evt_i        (evt),
    .op_busy_i    (op_busy),
    .pulse_busy_i (pulse_q),
    .fire_o       (fire)
  );

  gpo_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .cancel_i   (cancel),
    .tick_i     (tick_i),
    .active_o   (pulse_q),
    .active_d_o (pulse_d)
  );

  gpo_pin_drive u_drive (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (cfg.mode),
    .pulse_i  (pulse_d),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );

endmodule

// File: rtl/gpo_pulser_checker.sv
module gpo_pulser_checker #(
  parameter int unsigned CFG_W       = 16,
  parameter int unsigned MODE_LSB    = 2,
  parameter int unsigned DONE_EN_BIT = 14,
  parameter int unsigned RDS_EN_BIT  = 15,
  parameter int unsigned PULSE_TICKS = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CFG_W-1:0] cfg_i,
  input logic             op_start_i,
  input logic             op_done_i,
  input logic             rds_rdy_i,
  input logic             tick_i,
  input logic             pin_o,
  input logic             pin_oe_o
);

  logic [1:0] mode_in;
  logic [1:0] om1_q, om2_q;
  logic       busy_q;
  int         low_ticks_q;
  logic       irq_low;

  assign mode_in = cfg_i[MODE_LSB +: 2];
  assign irq_low = (om1_q == 2'b01) && !pin_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      om1_q       <= 2'b00;
      om2_q       <= 2'b00;
      busy_q      <= 1'b0;
      low_ticks_q <= 0;
    end else begin
      om1_q <= mode_in;
      om2_q <= om1_q;
      if (op_start_i)     busy_q <= 1'b1;
      else if (op_done_i) busy_q <= 1'b0;
      if (!irq_low)       low_ticks_q <= 0;
      else if (tick_i)    low_ticks_q <= low_ticks_q + 1;
    end
  end

  p_float_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_in == 2'b00) |=> !pin_oe_o && !pin_o);

  p_drive_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_in == 2'b10) |=> pin_oe_o && !pin_o);

  p_drive_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_in == 2'b11) |=> pin_oe_o && pin_o);

  p_done_fires_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_in == 2'b01 && cfg_i[DONE_EN_BIT] && op_done_i && om1_q == 2'b01 && pin_o)
      |=> !pin_o);

  p_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_low |-> (low_ticks_q < PULSE_TICKS));

  p_fall_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pin_o) && om1_q == 2'b01 && om2_q == 2'b01) |-> $past(op_done_i || rds_rdy_i));

  p_rds_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_in == 2'b01 && om1_q == 2'b01 && pin_o && cfg_i[DONE_EN_BIT] && busy_q && !op_done_i)
      |=> pin_o);

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !pin_oe_o && !pin_o);

endmodule

bind gpo_irq_pulser gpo_pulser_checker #(
  .CFG_W       (CFG_W),
  .MODE_LSB    (MODE_LSB),
  .DONE_EN_BIT (DONE_EN_BIT),
  .RDS_EN_BIT  (RDS_EN_BIT),
  .PULSE_TICKS (PULSE_TICKS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_i      (cfg_i),
  .op_start_i (op_start_i),
  .op_done_i  (op_done_i),
  .rds_rdy_i  (rds_rdy_i),
  .tick_i     (tick_i),
  .pin_o      (pin_o),
  .pin_oe_o   (pin_oe_o)
);

// File: tb/gpo_irq_pulser_test.sv
`timescale 1ns/1ps
module gpo_irq_pulser_test;

  localparam int P = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg = 16'h0000;
  logic        op_start = 1'b0, op_done = 1'b0, rds = 1'b0, tick = 1'b0;
  logic        pin, oe;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  gpo_irq_pulser #(.PULSE_TICKS(P)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .op_start_i(op_start),
    .op_done_i(op_done), .rds_rdy_i(rds), .tick_i(tick),
    .pin_o(pin), .pin_oe_o(oe)
  );

  // tick every fourth cycle
  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % 4 == 3);
  end

  // reference model
  int m_busy, m_act, m_left, m_pin, m_oe;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_act = 0; m_left = 0; m_pin = 0; m_oe = 0;
    end else begin
      int mode, old_act, ev;
      bit supp;
      mode = cfg[3:2];
      old_act = m_act;
      supp = cfg[14] && (m_busy != 0 || op_start);
      ev = (old_act == 0) && mode == 1 &&
           ((op_done && cfg[14]) || (rds && cfg[15] && !supp));
      if (mode != 1) m_act = 0;
      else if (old_act != 0) begin
        if (tick) begin
          m_left--;
          if (m_left == 0) m_act = 0;
        end
      end else if (ev != 0) begin
        m_act = 1; m_left = P;
      end
      if (op_start) m_busy = 1;
      else if (op_done) m_busy = 0;
      case (mode)
        0: begin m_pin = 0; m_oe = 0; end
        1: begin m_pin = (m_act != 0) ? 0 : 1; m_oe = 1; end
        2: begin m_pin = 0; m_oe = 1; end
        default: begin m_pin = 1; m_oe = 1; end
      endcase
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare against the model on every cycle
  always @(negedge clk) if (rst_n) begin
    chk(pin === m_pin[0], {cur_req, " pin vs model"}, pin, m_pin);
    chk(oe === m_oe[0], {cur_req, " oe vs model"}, oe, m_oe);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(bit s, bit d, bit r);
    op_start = s; op_done = d; rds = r;
    step();
    op_start = 0; op_done = 0; rds = 0;
  endtask

  task automatic measure(output int n, input bit noise);
    n = 0;
    while (pin === 1'b0 && n < 100) begin
      n++;
      if (noise && (n == 3 || n == 9)) strobe(0, 1, 1);
      else step();
    end
  endtask

  // watchdog
  initial begin
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w;
    step(3);
    chk(pin === 1'b0 && oe === 1'b0, "R1 reset outputs", {pin, oe}, 0);
    @(negedge clk) rst_n = 1;
    step(2);

    cur_req = "R2";
    cfg = 16'h0000; step(2);
    chk(oe === 1'b0, "R2 float oe", oe, 0);

    cur_req = "R3";
    cfg = 16'h0008; step(1);
    chk(oe === 1'b1 && pin === 1'b0, "R3 drive low", {pin, oe}, 1);
    cfg = 16'h000C; step(1);
    chk(oe === 1'b1 && pin === 1'b1, "R3 drive high", {pin, oe}, 3);

    cur_req = "R4";
    cfg = 16'h0004; step(1);
    chk(oe === 1'b1 && pin === 1'b1, "R4 irq idle", {pin, oe}, 3);

    cur_req = "R7";
    strobe(0, 1, 0); strobe(0, 0, 1); step(3);
    chk(pin === 1'b1, "R7 disabled events", pin, 1);

    cur_req = "R5";
    cfg = 16'h4004; step(2);
    strobe(1, 0, 0); step(5);
    strobe(0, 1, 0);
    chk(pin === 1'b0, "R5 completion pulse starts", pin, 0);
    measure(w, 0);
    chk(w >= 4*P-3 && w <= 4*P, "R5 pulse width cycles", w, 4*P);

    cur_req = "R6";
    cfg = 16'h8004; step(3);
    strobe(0, 0, 1);
    chk(pin === 1'b0, "R6 rds pulse starts", pin, 0);
    measure(w, 0);
    chk(w >= 4*P-3 && w <= 4*P, "R6 pulse width cycles", w, 4*P);

    cur_req = "R8";
    cfg = 16'hC004; step(3);
    strobe(1, 0, 0); step(2);
    strobe(0, 0, 1); step(4);
    strobe(0, 0, 1); step(1);
    chk(pin === 1'b1, "R8 rds held off while busy", pin, 1);
    strobe(0, 1, 0);
    chk(pin === 1'b0, "R8 completion first", pin, 0);
    measure(w, 0); step(2);
    chk(pin === 1'b1, "R8 suppressed rds not replayed", pin, 1);
    strobe(0, 0, 1);
    chk(pin === 1'b0, "R8 later rds pulses", pin, 0);
    measure(w, 0);

    cur_req = "R9";
    step(3);
    strobe(0, 0, 1);
    measure(w, 1);
    chk(w >= 4*P-3 && w <= 4*P, "R9 pulse not extended", w, 4*P);
    step(1);
    chk(pin === 1'b1, "R9 dropped events not queued", pin, 1);

    cur_req = "R10";
    strobe(0, 0, 1); step(3);
    chk(pin === 1'b0, "R10 pulse running", pin, 0);
    cfg = 16'hC00C; step(1);
    chk(pin === 1'b1 && oe === 1'b1, "R10 abort to drive high", {pin, oe}, 3);
    cfg = 16'hC004; step(1);
    chk(pin === 1'b1, "R10 return idle high", pin, 1);
    step(4*P);
    chk(pin === 1'b1, "R10 pulse stays cancelled", pin, 1);

    cur_req = "R11";
    strobe(0, 1, 1);
    chk(pin === 1'b0, "R11 combined event pulse", pin, 0);
    measure(w, 0); step(3);
    chk(pin === 1'b1, "R11 single pulse only", pin, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule